// File: doc/BRIEF.md
# Evicted-Line Victim Store

This block is a small fully associative holding area that sits beside a main cache with few ways. When the main cache evicts a line, that line and its line address are offered here and kept. On every access the main cache and this store are looked up at the same time. The lookup here is a purely combinational compare of the line address against every valid entry. A hit returns the line's data and dirty flag in the same cycle.

When the main cache decides to take a hit line back, it asserts a swap. In that one clock the hit entry leaves the store: its contents are already visible on the probe outputs. The line that the main cache gives up to make room takes over the same slot. Because a line only ever sits on one side of that exchange, the two structures never hold the same address. Eight entries are kept by default, and the least recently used one is chosen for replacement.

Insert and writeback are valid/ready streams. An insert transfers on a clock edge where both `ins_valid` and `ins_ready` are high. A writeback transfers where both `wb_valid` and `wb_ready` are high. Suppose an insert arrives while every entry is occupied and the least recently used entry is dirty. That entry is then offered on the writeback port in the same cycle, and the insert is held off until the writeback is taken: `ins_ready` follows `wb_ready`. The two transfers happen together. A clean entry chosen for replacement is dropped without any writeback. `wb_valid` never depends on `wb_ready`, and `ins_ready` is low in any cycle where `swap_en` is high.

Top module: `evict_store`

## Requirements
- R1: While and right after reset the store is empty: `probe_hit` is 0, `wb_valid` is 0 and `ins_ready` is 1.
- R2: `probe_hit` is 1 in the same cycle exactly when a valid entry's address equals `probe_addr`, and `probe_data`/`probe_dirty` then show that entry's line and dirty flag. A miss gives `probe_hit` 0.
- R3: As long as only absent addresses are inserted or swapped in, at most one entry matches any probe.
- R4: An insert while at least one entry is free is accepted at once (`ins_ready` 1), causes no writeback, and the line hits from the next cycle on.
- R5: An insert while all entries are valid replaces the least recently used entry. Recency counts only inserts and swap-ins, and the replaced line misses from the next cycle on.
- R6: When full with a dirty LRU entry, a pending insert raises `wb_valid` with that entry's address and data. `ins_ready` equals `wb_ready`, and both transfers happen on the same edge.
- R7: When full with a clean LRU entry, an insert is accepted with `wb_valid` 0 and the old line is dropped.
- R8: `swap_en` with a probe hit replaces the hit entry with the swap-in line in one cycle. The old address misses next cycle, the new one hits, and it becomes most recently used.
- R9: A swap with `swap_in_valid` 0 frees the hit entry, so the next insert fills it with no writeback.
- R10: `swap_en` without a probe hit changes nothing.
- R11: While `swap_en` is high, `ins_ready` is 0 and no insert is taken.
- R12: A probe without a swap does not change recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Evicted line offered |
| ins_ready | output | 1 | Store accepts the offered line |
| ins_addr | input | ADDR_W | Line address of the evicted line |
| ins_data | input | DATA_W | Line contents |
| ins_dirty | input | 1 | Line is modified |
| probe_addr | input | ADDR_W | Line address being looked up |
| probe_hit | output | 1 | A valid entry matches |
| probe_data | output | DATA_W | Matching line contents |
| probe_dirty | output | 1 | Matching line is modified |
| swap_en | input | 1 | Exchange the hit line with the swap-in line |
| swap_in_valid | input | 1 | The main cache gives up a real line |
| swap_in_addr | input | ADDR_W | Address of the line given up |
| swap_in_data | input | DATA_W | Contents of the line given up |
| swap_in_dirty | input | 1 | Line given up is modified |
| wb_valid | output | 1 | Dirty LRU line offered to lower memory |
| wb_ready | input | 1 | Lower memory accepts the writeback |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_data | output | DATA_W | Writeback line contents |

## Verification
A corrupted recency order stays invisible until the store is full. It then shows on the next insert, as the wrong address on `wb_addr`, or as `wb_valid` wrongly high or low when the dirty flag of the wrong entry is consulted. It also shows one cycle later as a probe that hits a line that should have gone. A stale valid bit or tag shows on the very next probe of that address as a wrong `probe_hit` or wrong data. A swap that writes the wrong slot shows within a cycle as a surviving old address or a missing new one. Comparing every output against a recency-ordered model in every cycle therefore catches each of these faults at its first observable cycle.

// File: rtl/vb_pkg.sv
package vb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_INSERT = 2'd1,
    OP_SWAP   = 2'd2
  } vb_op_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int N      = 8,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 64,
  parameter int IW     = $clog2(N)
) (
  input  logic [N-1:0]      ent_valid,
  input  logic [ADDR_W-1:0] ent_tag  [N],
  input  logic [DATA_W-1:0] ent_data [N],
  input  logic [N-1:0]      ent_dirty,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [N-1:0]      match_vec,
  output logic              any_match,
  output logic [IW-1:0]     match_idx,
  output logic [DATA_W-1:0] match_data,
  output logic              match_dirty
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = ent_valid[g] && (ent_tag[g] == look_addr);
  end

  assign any_match = |match_vec;

  // One-hot select by OR-reduction; relies on at most one match (R3)
  always_comb begin
    match_idx   = '0;
    match_data  = '0;
    match_dirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) begin
        match_idx   = match_idx | IW'(i);
        match_data  = match_data | ent_data[i];
        match_dirty = match_dirty | ent_dirty[i];
      end
    end
  end
endmodule

// File: rtl/vb_age.sv
module vb_age #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [N-1:0]  lru_vec,
  output logic [IW-1:0] lru_idx
);
  // Ages form a permutation of 0..N-1; age N-1 marks the least recent slot
  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (touch_idx == IW'(i))
          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx])
          age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign lru_vec[g] = (age_q[g] == IW'(N - 1));
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++)
      if (lru_vec[i]) lru_idx = IW'(i);
  end
endmodule

// File: rtl/evict_store.sv
module evict_store #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              ins_dirty,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic [DATA_W-1:0] probe_data,
  output logic              probe_dirty,
  input  logic              swap_en,
  input  logic              swap_in_valid,
  input  logic [ADDR_W-1:0] swap_in_addr,
  input  logic [DATA_W-1:0] swap_in_data,
  input  logic              swap_in_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  import vb_pkg::*;

  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [ADDR_W-1:0]  tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];

  logic [ENTRIES-1:0] hit_vec;
  logic [IW-1:0]      hit_idx;
  logic [ENTRIES-1:0] lru_vec;
  logic [IW-1:0]      lru_idx;
  logic [IW-1:0]      free_idx;
  logic [IW-1:0]      slot;
  logic               full;
  logic               lru_dirty;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [DATA_W-1:0]  wr_data;
  logic               wr_dirty;
  vb_op_e             op;

  vb_match #(.N(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IW(IW)) u_match (
    .ent_valid   (valid_q),
    .ent_tag     (tag_q),
    .ent_data    (data_q),
    .ent_dirty   (dirty_q),
    .look_addr   (probe_addr),
    .match_vec   (hit_vec),
    .any_match   (probe_hit),
    .match_idx   (hit_idx),
    .match_data  (probe_data),
    .match_dirty (probe_dirty)
  );

  vb_age #(.N(ENTRIES), .IW(IW)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (wr_en),
    .touch_idx (slot),
    .lru_vec   (lru_vec),
    .lru_idx   (lru_idx)
  );

  // Lowest-numbered free slot
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IW'(i);
  end

  assign full      = &valid_q;
  assign lru_dirty = dirty_q[lru_idx];

  // Swap wins the cycle; a full store with dirty LRU waits for the writeback sink
  assign ins_ready = !swap_en && (!full || !lru_dirty || wb_ready);
  assign wb_valid  = ins_valid && !swap_en && full && lru_dirty;
  assign wb_addr   = tag_q[lru_idx];
  assign wb_data   = data_q[lru_idx];

  always_comb begin
    if (swap_en && probe_hit)        op = OP_SWAP;
    else if (ins_valid && ins_ready) op = OP_INSERT;
    else                             op = OP_IDLE;
  end

  always_comb begin
    if (op == OP_SWAP) slot = hit_idx;
    else if (full)     slot = lru_idx;
    else               slot = free_idx;
  end

  assign wr_en    = (op == OP_INSERT) || ((op == OP_SWAP) && swap_in_valid);
  assign wr_addr  = (op == OP_SWAP) ? swap_in_addr  : ins_addr;
  assign wr_data  = (op == OP_SWAP) ? swap_in_data  : ins_data;
  assign wr_dirty = (op == OP_SWAP) ? swap_in_dirty : ins_dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= '0;
    else if ((op == OP_SWAP) && !swap_in_valid)
      valid_q[slot] <= 1'b0;
    else if (wr_en)
      valid_q[slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[slot]   <= wr_addr;
      data_q[slot]  <= wr_data;
      dirty_q[slot] <= wr_dirty;
    end
  end
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] lru_vec,
  input logic         probe_hit,
  input logic         swap_en,
  input logic         ins_valid,
  input logic         ins_ready,
  input logic         wb_valid,
  input logic         wb_ready
);
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!probe_hit && !wb_valid && ins_ready));

  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r5_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(lru_vec));

  a_r6_wb_needs_insert: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (ins_valid && !swap_en));

  a_r6_stall_only_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready && !swap_en) |-> (wb_valid && !wb_ready));

  a_r11_swap_blocks_insert: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |-> !ins_ready);
endmodule

bind evict_store vb_checker #(.N(ENTRIES)) u_vb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .hit_vec   (hit_vec),
  .lru_vec   (lru_vec),
  .probe_hit (probe_hit),
  .swap_en   (swap_en),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .wb_valid  (wb_valid),
  .wb_ready  (wb_ready)
);

// File: tb/evict_store_tb_top.sv
module evict_store_tb_top;
  localparam int N  = 8;
  localparam int AW = 28;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0;
  logic          ins_ready;
  logic [AW-1:0] ins_addr = '0;
  logic [DW-1:0] ins_data = '0;
  logic          ins_dirty = 1'b0;
  logic [AW-1:0] probe_addr = '0;
  logic          probe_hit;
  logic [DW-1:0] probe_data;
  logic          probe_dirty;
  logic          swap_en = 1'b0;
  logic          swap_in_valid = 1'b0;
  logic [AW-1:0] swap_in_addr = '0;
  logic [DW-1:0] swap_in_data = '0;
  logic          swap_in_dirty = 1'b0;
  logic          wb_valid;
  logic          wb_ready = 1'b0;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  always #5 clk = ~clk;

  evict_store #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  int    n_checks = 0;
  int    n_fail   = 0;
  string focus    = "reset";
  bit    finished = 0;

  // Reference model: lines in recency order, index 0 is most recent
  logic [AW-1:0] m_addr  [$];
  logic [DW-1:0] m_data  [$];
  bit            m_dirty [$];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s (%s): actual=%h expected=%h", req, what, focus, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dat_of(logic [AW-1:0] a);
    return {8'hD5, 28'(a), 28'(a ^ 28'h5A5A5A5)};
  endfunction

  task automatic tick();
    int  hi;
    bit  full, lru_d, e_ready, e_wbv;
    #2;
    hi = -1;
    foreach (m_addr[k]) if (m_addr[k] == probe_addr) hi = k;
    full    = (m_addr.size() == N);
    lru_d   = full ? m_dirty[N-1] : 1'b0;
    e_wbv   = ins_valid && !swap_en && full && lru_d;
    e_ready = !swap_en && (!full || !lru_d || wb_ready);
    chk(swap_en ? "R8" : "R2", "probe_hit", 64'(probe_hit), 64'(hi >= 0));
    if (hi >= 0) begin
      chk(swap_en ? "R8" : "R2", "probe_data", probe_data, m_data[hi]);
      chk(swap_en ? "R8" : "R2", "probe_dirty", 64'(probe_dirty), 64'(m_dirty[hi]));
    end
    chk(swap_en ? "R11" : (full ? "R6" : "R4"), "ins_ready", 64'(ins_ready), 64'(e_ready));
    chk(lru_d ? "R6" : "R7", "wb_valid", 64'(wb_valid), 64'(e_wbv));
    if (e_wbv) begin
      chk("R6", "wb_addr", 64'(wb_addr), 64'(m_addr[N-1]));
      chk("R6", "wb_data", wb_data, m_data[N-1]);
    end
    if (swap_en && hi >= 0) begin
      m_addr.delete(hi); m_data.delete(hi); m_dirty.delete(hi);
      if (swap_in_valid) begin
        m_addr.push_front(swap_in_addr);
        m_data.push_front(swap_in_data);
        m_dirty.push_front(swap_in_dirty);
      end
    end else if (ins_valid && e_ready) begin
      if (full) begin
        void'(m_addr.pop_back()); void'(m_data.pop_back()); void'(m_dirty.pop_back());
      end
      m_addr.push_front(ins_addr);
      m_data.push_front(ins_data);
      m_dirty.push_front(ins_dirty);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ins_valid = 0; swap_en = 0; swap_in_valid = 0; wb_ready = 0;
  endtask

  task automatic do_insert(logic [AW-1:0] a, bit d);
    idle_inputs();
    ins_valid = 1; ins_addr = a; ins_data = dat_of(a); ins_dirty = d;
    probe_addr = a;
    tick();
    ins_valid = 0;
  endtask

  task automatic do_probe(logic [AW-1:0] a);
    idle_inputs();
    probe_addr = a;
    tick();
  endtask

  task automatic do_swap(logic [AW-1:0] hit_a, bit in_v, logic [AW-1:0] in_a, bit in_d);
    idle_inputs();
    probe_addr = hit_a; swap_en = 1; swap_in_valid = in_v;
    swap_in_addr = in_a; swap_in_data = dat_of(in_a); swap_in_dirty = in_d;
    tick();
    idle_inputs();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] fresh;
    @(negedge clk); @(negedge clk);
    probe_addr = 28'h100;
    #1;
    // R1: reset state
    chk("R1", "probe_hit", 64'(probe_hit), 64'd0);
    chk("R1", "wb_valid", 64'(wb_valid), 64'd0);
    chk("R1", "ins_ready", 64'(ins_ready), 64'd1);
    @(negedge clk);
    rst_n = 1;
    focus = "R1 first cycle";
    do_probe(28'h100);

    focus = "R4 fill";
    for (int i = 0; i < N; i++) do_insert(28'h100 + 28'(i), i[0]);

    focus = "R12 probes keep order";
    for (int i = N - 1; i >= 0; i--) do_probe(28'h100 + 28'(i));

    focus = "R7 R5 clean LRU dropped";
    do_insert(28'h200, 1'b0);
    do_probe(28'h100);

    focus = "R6 dirty LRU stall";
    idle_inputs();
    ins_valid = 1; ins_addr = 28'h201; ins_data = dat_of(28'h201); ins_dirty = 1;
    probe_addr = 28'h101;
    tick(); tick();
    wb_ready = 1;
    tick();
    idle_inputs();
    do_probe(28'h101);
    do_probe(28'h201);

    focus = "R8 swap";
    do_swap(28'h103, 1'b1, 28'h300, 1'b1);
    do_probe(28'h103);
    do_probe(28'h300);

    focus = "R9 swap frees slot";
    do_swap(28'h104, 1'b0, 28'h0, 1'b0);
    do_probe(28'h104);
    do_insert(28'h202, 1'b1);
    do_probe(28'h202);

    focus = "R10 swap on miss";
    do_swap(28'h999, 1'b1, 28'h301, 1'b0);
    do_probe(28'h301);

    focus = "R11 swap with insert";
    idle_inputs();
    probe_addr = 28'h105; swap_en = 1; swap_in_valid = 1;
    swap_in_addr = 28'h302; swap_in_data = dat_of(28'h302); swap_in_dirty = 0;
    ins_valid = 1; ins_addr = 28'h203; ins_data = dat_of(28'h203); ins_dirty = 0;
    wb_ready = 1;
    tick();
    idle_inputs();
    do_probe(28'h203);
    do_probe(28'h302);

    focus = "R5 R3 mixed traffic";
    fresh = 28'h1000;
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom_range(0, 7));
      if (m_addr.size() > 0 && $urandom_range(0, 3) != 0)
        probe_addr = m_addr[$urandom_range(0, m_addr.size() - 1)];
      else
        probe_addr = 28'h1000 + 28'($urandom_range(0, 4095));
      swap_en       = (r == 0);
      swap_in_valid = ($urandom_range(0, 3) != 0);
      swap_in_addr  = fresh; swap_in_data = dat_of(fresh);
      swap_in_dirty = $urandom_range(0, 1) != 0;
      fresh++;
      ins_valid = (r >= 3);
      ins_addr  = fresh; ins_data = dat_of(fresh);
      ins_dirty = $urandom_range(0, 1) != 0;
      fresh++;
      wb_ready  = $urandom_range(0, 2) != 0;
      tick();
    end
    idle_inputs();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule